// File: doc/BRIEF.md
# Dual-Threshold Time-over-Threshold Hit Recorder

This block turns the digital outputs of two discriminators per strip channel into time-stamped hit records. The two discriminators are a low-threshold readout discriminator and a high-threshold confirmation discriminator. Both are sampled on a slow acquisition tick, and every event time is a count of these ticks. A rising low discriminator opens an acceptance window. The hit is kept only if the high discriminator is seen high inside that window. For a kept hit, two records go into that channel's FIFO: one for the rising transition and one for the falling transition of the low discriminator. The gap between their timestamps is the time over threshold, which later converts to pulse height with no analog-to-digital converter.

The block runs on one fast clock. An acquisition tick lasts NCH fast cycles. Each channel owns one fast cycle of every tick, and in that cycle it may place one record on the shared output. A long pulse is cut off at a parameterized limit and its forced end record is flagged. Writes that find a full FIFO are lost, and each channel keeps a saturating count of those losses.

Top module: `tot_hit_recorder`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, `out_valid` is 0, `out_rec` is 0 and every drop counter is 0.
- R2: Record layout is `out_rec[TS_W-1:0]` = timestamp, bit `TS_W` = overflow flag, bit `TS_W+1` = edge (0 rising, 1 falling), bits `TS_W+2` upward (`CH_W` of them) = channel number. A low pulse that has the high input high in its first sampled tick yields a rising record followed by a falling record, both carrying the channel number.
- R3: The falling record's timestamp minus the rising record's timestamp, modulo 2^TS_W, equals the number of acquisition ticks in which the low input was sampled high.
- R4: The acceptance window is DOM_LEN ticks long, and the tick of the low rising edge is the first of them. A high input first seen in window tick DOM_LEN is still accepted. One first seen in tick DOM_LEN+1 produces no record.
- R5: A pulse produces no record if the low input falls before the high input is seen, if the high input never fires, or if only the high input pulses.
- R6: If the low input is still high TOT_MAX ticks after the rising edge, a falling record is forced with timestamp difference TOT_MAX and overflow 1, and the later real fall writes nothing. A pulse lasting exactly TOT_MAX ticks ends normally with overflow 0.
- R7: Count fast cycles from 1 at the first rising clock edge with reset high. A record from channel i is valid only in a cycle whose count modulo NCH is (i+1) modulo NCH. Output slots are open only in one tick out of every SLOT_DIV.
- R8: In every cycle in which `out_valid` is 0, `out_rec` is all zeros.
- R9: A record written while its channel FIFO is full is dropped and adds one to that channel's drop counter. Records delivered plus records dropped equals records generated. Other channels' counters do not change.
- R10: A drop counter stops at 2^DROP_W-1 and never wraps.
- R11: Channels work independently. Simultaneous hits on two channels each yield their own record pair, tagged with their own channel number and carrying their own duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one acquisition tick is NCH cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| lo_cmp | input | NCH | Low (readout) discriminator output per channel, asynchronous |
| hi_cmp | input | NCH | High (confirmation) discriminator output per channel, asynchronous |
| out_valid | output | 1 | A record is presented on `out_rec` this cycle |
| out_rec | output | TS_W+2+CH_W | Record: channel, edge, overflow, timestamp |
| drop_cnt | output | NCH*DROP_W | Saturating dropped-record counters, channel c at bits c*DROP_W upward |

## Verification
The bench builds the block with eight channels and 16-bit timestamps. It shrinks the FIFO depth to 2, opens output slots only every second tick and uses 2-bit drop counters. With these settings a train of one-tick pulses overruns a FIFO, the drop count saturates, and the conservation of records can be checked within a few dozen ticks. The overflow limit is set to 20 ticks, so forced ends and the exact-limit boundary come at small cost. The window stays at 7 ticks, so tick 7 (accepted) and tick 8 (rejected) can both be driven.

// File: rtl/tot_pkg.sv
// Shared definitions for the time-over-threshold hit recorder.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tot_pkg;
    // Per-channel acceptance state
    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for a low-discriminator rising edge
        ST_PEND,   // window open, waiting for high-discriminator confirmation
        ST_HOLD,   // accepted, measuring until the low discriminator falls
        ST_DRAIN   // forced end written, waiting for the real fall
    } chan_state_t;

    localparam logic EDGE_LEAD  = 1'b0;
    localparam logic EDGE_TRAIL = 1'b1;
endpackage

// File: rtl/tot_tick_gen.sv
// Timebase: splits the fast clock into acquisition ticks of NCH cycles,
// gives the current slot index, the slot-open frame and the tick timestamp.
// Assumes NCH >= 2 and SLOT_DIV >= 1.
module tot_tick_gen #(
    parameter int NCH      = 8,
    parameter int SLOT_DIV = 1,
    parameter int TS_W     = 16,
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [CH_W-1:0] sub,
    output logic            tick,
    output logic            slot_open,
    output logic [TS_W-1:0] ts
);
    logic [CH_W-1:0] sub_q;
    logic [TS_W-1:0] ts_q;

    assign tick = (sub_q == CH_W'(NCH - 1));
    assign sub  = sub_q;
    assign ts   = ts_q;

    // Slot index within the current tick
    always_ff @(posedge clk) begin
        if (!rst_n)      sub_q <= '0;
        else if (tick)   sub_q <= '0;
        else             sub_q <= sub_q + 1'b1;
    end

    // Tick timestamp, wraps silently
    always_ff @(posedge clk) begin
        if (!rst_n)      ts_q <= '0;
        else if (tick)   ts_q <= ts_q + 1'b1;
    end

    generate
        if (SLOT_DIV > 1) begin : g_frame
            localparam int FR_W = $clog2(SLOT_DIV);
            logic [FR_W-1:0] frame_q;
            // Frame counter selecting which ticks carry output slots
            always_ff @(posedge clk) begin
                if (!rst_n)     frame_q <= '0;
                else if (tick)  frame_q <= (frame_q == FR_W'(SLOT_DIV - 1)) ? '0 : frame_q + 1'b1;
            end
            assign slot_open = (frame_q == '0);
        end else begin : g_noframe
            assign slot_open = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/tot_chan.sv
// One channel: synchronizes both discriminators on the tick, detects the
// low rising edge, runs the acceptance window and the over-threshold limit,
// and emits at most one record request per tick (combinational, on tick).
// Assumes 2 <= DOM_LEN <= TOT_MAX < 2**TS_W.
module tot_chan
    import tot_pkg::*;
#(
    parameter int TS_W    = 16,
    parameter int DOM_LEN = 7,
    parameter int TOT_MAX = 255,
    localparam int DW     = $clog2(DOM_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [TS_W-1:0] ts,
    input  logic            lo_in,
    input  logic            hi_in,
    output logic            wr,
    output logic            wr_edge,
    output logic            wr_ovf,
    output logic [TS_W-1:0] wr_ts
);
    logic            lo_s1, lo_s2, lo_prev, hi_s1, hi_s2;
    chan_state_t     st_q, st_n;
    logic [DW-1:0]   dom_q, dom_n;
    logic [TS_W-1:0] lead_q, lead_n;
    logic [TS_W-1:0] elapsed;
    logic            lo_rise;

    // Two-stage synchronizers plus edge history, advanced once per tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_s1 <= 1'b0; lo_s2 <= 1'b0; lo_prev <= 1'b0;
            hi_s1 <= 1'b0; hi_s2 <= 1'b0;
        end else if (tick) begin
            lo_s1 <= lo_in; lo_s2 <= lo_s1; lo_prev <= lo_s2;
            hi_s1 <= hi_in; hi_s2 <= hi_s1;
        end
    end

    assign lo_rise = lo_s2 & ~lo_prev;
    assign elapsed = ts - lead_q;

    // Acceptance and measurement decisions for the current tick
    always_comb begin
        st_n    = st_q;
        dom_n   = dom_q;
        lead_n  = lead_q;
        wr      = 1'b0;
        wr_edge = EDGE_LEAD;
        wr_ovf  = 1'b0;
        wr_ts   = lead_q;
        if (tick) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (lo_rise) begin
                        lead_n = ts;
                        dom_n  = DW'(1);
                        if (hi_s2) begin
                            wr    = 1'b1;
                            wr_ts = ts;
                            st_n  = ST_HOLD;
                        end else begin
                            st_n  = ST_PEND;
                        end
                    end
                end
                ST_PEND: begin
                    if (!lo_s2) begin
                        st_n = ST_IDLE;
                    end else if (hi_s2) begin
                        wr   = 1'b1;
                        st_n = ST_HOLD;
                    end else if (dom_q == DW'(DOM_LEN - 1)) begin
                        st_n = ST_IDLE;
                    end else begin
                        dom_n = dom_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (!lo_s2) begin
                        wr      = 1'b1;
                        wr_edge = EDGE_TRAIL;
                        wr_ts   = ts;
                        st_n    = ST_IDLE;
                    end else if (elapsed == TS_W'(TOT_MAX)) begin
                        wr      = 1'b1;
                        wr_edge = EDGE_TRAIL;
                        wr_ovf  = 1'b1;
                        wr_ts   = ts;
                        st_n    = ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (!lo_s2) st_n = ST_IDLE;
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // State, window count and leading timestamp registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            dom_q  <= '0;
            lead_q <= '0;
        end else begin
            st_q   <= st_n;
            dom_q  <= dom_n;
            lead_q <= lead_n;
        end
    end
endmodule

// File: rtl/tot_fifo.sv
// Small synchronous FIFO with first-word fall-through head.
// Writes when full and reads when empty are ignored; the owner counts losses.
module tot_fifo #(
    parameter int W     = 21,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         rd,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_wr, do_rd;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign do_wr = wr & ~full;
    assign do_rd = rd & ~empty;
    assign dout  = mem[rp_q];

    // Storage array, written only on an accepted write
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp_q] <= din;
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_rd) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            if (do_wr && !do_rd)      cnt_q <= cnt_q + 1'b1;
            else if (do_rd && !do_wr) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/tot_slot_mux.sv
// Time-slot merger: in slot i of an open tick, pops channel i's FIFO head
// onto the registered shared output; an empty channel gives an idle slot.
module tot_slot_mux #(
    parameter int NCH   = 8,
    parameter int REC_W = 21,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CH_W-1:0]           sub,
    input  logic                      slot_open,
    input  logic [NCH-1:0][REC_W-1:0] heads,
    input  logic [NCH-1:0]            empty,
    output logic [NCH-1:0]            pop,
    output logic                      out_valid,
    output logic [REC_W-1:0]          out_rec
);
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_pop
            assign pop[i] = slot_open && (sub == CH_W'(i)) && !empty[i];
        end
    endgenerate

    // Registered output slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rec   <= '0;
        end else begin
            out_valid <= |pop;
            out_rec   <= (|pop) ? heads[sub] : '0;
        end
    end
endmodule

// File: rtl/tot_hit_recorder.sv
// Top: NCH channels of dual-threshold time-over-threshold capture, one FIFO
// and one saturating drop counter each, merged onto one output by slot.
// Assumes asynchronous discriminator inputs and one clock domain.
module tot_hit_recorder #(
    parameter int NCH        = 8,
    parameter int TS_W       = 16,
    parameter int DOM_LEN    = 7,
    parameter int TOT_MAX    = 255,
    parameter int FIFO_DEPTH = 16,
    parameter int SLOT_DIV   = 1,
    parameter int DROP_W     = 8,
    localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int REC_W     = TS_W + 2 + CH_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        lo_cmp,
    input  logic [NCH-1:0]        hi_cmp,
    output logic                  out_valid,
    output logic [REC_W-1:0]      out_rec,
    output logic [NCH*DROP_W-1:0] drop_cnt
);
    logic [CH_W-1:0]           sub_q;
    logic                      tick;
    logic                      slot_open;
    logic [TS_W-1:0]           ts_q;
    logic [NCH-1:0]            ch_wr, ch_edge, ch_ovf;
    logic [TS_W-1:0]           ch_ts [NCH];
    logic [REC_W-1:0]          ch_rec [NCH];
    logic [NCH-1:0][REC_W-1:0] head;
    logic [NCH-1:0]            fifo_empty, fifo_full, pop;

    tot_tick_gen #(.NCH(NCH), .SLOT_DIV(SLOT_DIV), .TS_W(TS_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .sub(sub_q), .tick(tick),
        .slot_open(slot_open), .ts(ts_q)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic [DROP_W-1:0] drop_q;

            tot_chan #(.TS_W(TS_W), .DOM_LEN(DOM_LEN), .TOT_MAX(TOT_MAX)) u_chan (
                .clk(clk), .rst_n(rst_n), .tick(tick), .ts(ts_q),
                .lo_in(lo_cmp[c]), .hi_in(hi_cmp[c]),
                .wr(ch_wr[c]), .wr_edge(ch_edge[c]), .wr_ovf(ch_ovf[c]), .wr_ts(ch_ts[c])
            );

            assign ch_rec[c] = {CH_W'(c), ch_edge[c], ch_ovf[c], ch_ts[c]};

            tot_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
                .clk(clk), .rst_n(rst_n), .wr(ch_wr[c]), .din(ch_rec[c]),
                .rd(pop[c]), .dout(head[c]), .empty(fifo_empty[c]), .full(fifo_full[c])
            );

            // Saturating count of writes lost to a full FIFO
            always_ff @(posedge clk) begin
                if (!rst_n)
                    drop_q <= '0;
                else if (ch_wr[c] && fifo_full[c] && (drop_q != {DROP_W{1'b1}}))
                    drop_q <= drop_q + 1'b1;
            end

            assign drop_cnt[c*DROP_W +: DROP_W] = drop_q;
        end
    endgenerate

    tot_slot_mux #(.NCH(NCH), .REC_W(REC_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .sub(sub_q), .slot_open(slot_open),
        .heads(head), .empty(fifo_empty), .pop(pop),
        .out_valid(out_valid), .out_rec(out_rec)
    );
endmodule

// File: rtl/tot_hit_recorder_chk.sv
// Property checker for tot_hit_recorder, attached by bind below.
module tot_hit_recorder_chk #(
    parameter int NCH    = 8,
    parameter int TS_W   = 16,
    parameter int DROP_W = 8,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int REC_W = TS_W + 2 + CH_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  out_valid,
    input logic [REC_W-1:0]      out_rec,
    input logic [CH_W-1:0]       sub,
    input logic                  tick,
    input logic [NCH-1:0]        ch_wr,
    input logic [NCH*DROP_W-1:0] drop_cnt
);
    // R7: a presented record belongs to the slot of the previous cycle
    p_slot_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_rec[TS_W+2 +: CH_W] == $past(sub)));

    // R6: an overflow flag only ever appears on a falling record
    p_ovf_trailing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_rec[TS_W]) |-> out_rec[TS_W+1]);

    // R3: channels request writes only on an acquisition tick
    p_write_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_wr) |-> tick);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_drop
            // R9: a drop counter moves only by single increments
            p_drop_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (drop_cnt[c*DROP_W +: DROP_W] != $past(drop_cnt[c*DROP_W +: DROP_W])) |->
                ({1'b0, drop_cnt[c*DROP_W +: DROP_W]} ==
                 {1'b0, $past(drop_cnt[c*DROP_W +: DROP_W])} + 1'b1));
            // R10: a saturated counter stays saturated
            p_drop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(drop_cnt[c*DROP_W +: DROP_W]) == {DROP_W{1'b1}}) |->
                (drop_cnt[c*DROP_W +: DROP_W] == {DROP_W{1'b1}}));
        end
    endgenerate
endmodule

bind tot_hit_recorder tot_hit_recorder_chk #(.NCH(NCH), .TS_W(TS_W), .DROP_W(DROP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_rec(out_rec),
    .sub(sub_q), .tick(tick), .ch_wr(ch_wr), .drop_cnt(drop_cnt)
);

// File: tb/sim_tot_hit_recorder.sv
`timescale 1ns/1ps
module sim_tot_hit_recorder;
    localparam int NCH = 8, TS_W = 16, DOM_LEN = 7, TOT_MAX = 20;
    localparam int FIFO_DEPTH = 2, SLOT_DIV = 2, DROP_W = 2;
    localparam int CH_W = 3, REC_W = TS_W + 2 + CH_W, TK = NCH;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NCH-1:0] lo = '0, hi = '0;
    logic out_valid;
    logic [REC_W-1:0] out_rec;
    logic [NCH*DROP_W-1:0] drop_cnt;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, n_log = 0, bad_slot = 0, bad_idle = 0;
    logic [REC_W-1:0] lg_rec [0:1023];

    tot_hit_recorder #(.NCH(NCH), .TS_W(TS_W), .DOM_LEN(DOM_LEN), .TOT_MAX(TOT_MAX),
        .FIFO_DEPTH(FIFO_DEPTH), .SLOT_DIV(SLOT_DIV), .DROP_W(DROP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lo_cmp(lo), .hi_cmp(hi),
        .out_valid(out_valid), .out_rec(out_rec), .drop_cnt(drop_cnt));

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic int f_ch(logic [REC_W-1:0] r);   return int'(r[TS_W+2 +: CH_W]); endfunction
    function automatic int f_edge(logic [REC_W-1:0] r); return int'(r[TS_W+1]); endfunction
    function automatic int f_ovf(logic [REC_W-1:0] r);  return int'(r[TS_W]); endfunction
    function automatic int f_ts(logic [REC_W-1:0] r);   return int'(r[TS_W-1:0]); endfunction
    function automatic int f_drop(int c);               return int'(drop_cnt[c*DROP_W +: DROP_W]); endfunction

    // Output monitor: logs records, checks slot position (R7) and idle value (R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (n_log < 1024) lg_rec[n_log] = out_rec;
                if ((cyc % NCH) != ((f_ch(out_rec) + 1) % NCH)) bad_slot++;
                n_log++;
            end else if (out_rec != '0) begin
                bad_idle++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive a pattern on the masked channels, one step per acquisition tick
    task automatic drive(input logic [NCH-1:0] m, input int lo_t, input int hi_d, input int hi_t, input int total);
        for (int t = 0; t < total; t++) begin
            lo = (t < lo_t) ? m : '0;
            hi = (t >= hi_d && t < hi_d + hi_t) ? m : '0;
            repeat (TK) @(negedge clk);
        end
        lo = '0;
        hi = '0;
    endtask

    task automatic settle();
        repeat (TK * 14) @(negedge clk);
    endtask

    task automatic check_pair(input int base, input int ch, input int tot, input int ovf, input string req);
        chk(n_log - base == 2, req, "record count", n_log - base, 2);
        if (n_log - base >= 2) begin
            chk(f_edge(lg_rec[base]) == 0, req, "first edge", f_edge(lg_rec[base]), 0);
            chk(f_edge(lg_rec[base+1]) == 1, req, "second edge", f_edge(lg_rec[base+1]), 1);
            chk(f_ch(lg_rec[base]) == ch && f_ch(lg_rec[base+1]) == ch, req, "channel",
                f_ch(lg_rec[base+1]), ch);
            chk(f_ovf(lg_rec[base+1]) == ovf, req, "overflow flag", f_ovf(lg_rec[base+1]), ovf);
            chk(((f_ts(lg_rec[base+1]) - f_ts(lg_rec[base])) & 16'hFFFF) == tot, req, "duration",
                (f_ts(lg_rec[base+1]) - f_ts(lg_rec[base])) & 16'hFFFF, tot);
        end
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(out_rec == '0, "R1", "out_rec after reset", int'(out_rec), 0);
        chk(drop_cnt == '0, "R1", "drop counters after reset", int'(drop_cnt), 0);
    endtask

    task automatic t_basic();
        int b;
        b = n_log; drive(8'h04, 5, 0, 2, 8); settle();
        check_pair(b, 2, 5, 0, "R2");
        b = n_log; drive(8'h80, 1, 0, 1, 3); settle();
        check_pair(b, 7, 1, 0, "R3");
    endtask

    task automatic t_window();
        int b;
        b = n_log; drive(8'h10, 10, 6, 4, 12); settle();
        check_pair(b, 4, 10, 0, "R4");
        b = n_log; drive(8'h10, 10, 7, 3, 12); settle();
        chk(n_log == b, "R4", "late confirmation records", n_log - b, 0);
    endtask

    task automatic t_discard();
        int b;
        b = n_log; drive(8'h01, 3, 4, 2, 8); settle();
        chk(n_log == b, "R5", "fall before confirmation", n_log - b, 0);
        b = n_log; drive(8'h01, 4, 0, 0, 6); settle();
        chk(n_log == b, "R5", "no confirmation", n_log - b, 0);
        b = n_log; drive(8'h01, 0, 0, 3, 5); settle();
        chk(n_log == b, "R5", "high input alone", n_log - b, 0);
    endtask

    task automatic t_ovf();
        int b;
        b = n_log; drive(8'h20, 25, 0, 2, 28); settle();
        check_pair(b, 5, TOT_MAX, 1, "R6");
        b = n_log; drive(8'h20, TOT_MAX, 0, 2, TOT_MAX + 3); settle();
        check_pair(b, 5, TOT_MAX, 0, "R6");
    endtask

    task automatic t_multi();
        int b, n1, n6, t1, t6;
        b = n_log; drive(8'h42, 4, 0, 2, 6); settle();
        chk(n_log - b == 4, "R11", "record count", n_log - b, 4);
        n1 = 0; n6 = 0; t1 = 0; t6 = 0;
        for (int k = b; k < n_log && k < 1024; k++) begin
            if (f_ch(lg_rec[k]) == 1) begin
                n1++; t1 = f_edge(lg_rec[k]) ? t1 + f_ts(lg_rec[k]) : t1 - f_ts(lg_rec[k]);
            end else if (f_ch(lg_rec[k]) == 6) begin
                n6++; t6 = f_edge(lg_rec[k]) ? t6 + f_ts(lg_rec[k]) : t6 - f_ts(lg_rec[k]);
            end
        end
        chk(n1 == 2 && n6 == 2, "R11", "records per channel", n1 * 10 + n6, 22);
        chk(t1 == 4, "R11", "channel 1 duration", t1, 4);
        chk(t6 == 4, "R11", "channel 6 duration", t6, 4);
    endtask

    task automatic t_drop();
        int b, d;
        b = n_log;
        for (int k = 0; k < 3; k++) drive(8'h08, 1, 0, 1, 2);
        settle();
        d = f_drop(3);
        chk(d >= 1, "R9", "drops after overrun", d, 1);
        chk((n_log - b) + d == 6, "R9", "delivered plus dropped", (n_log - b) + d, 6);
        chk(f_drop(0) == 0 && f_drop(5) == 0, "R9", "other channel drops", f_drop(0) + f_drop(5), 0);
        for (int k = 0; k < 6; k++) drive(8'h08, 1, 0, 1, 2);
        settle();
        chk(f_drop(3) == 3, "R10", "saturated drop count", f_drop(3), 3);
    endtask

    task automatic t_slots();
        chk(bad_slot == 0, "R7", "records outside their slot", bad_slot, 0);
        chk(bad_idle == 0, "R8", "non-zero idle slots", bad_idle, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        repeat (TK * 4) @(negedge clk);
        t_basic();
        t_window();
        t_discard();
        t_ovf();
        t_multi();
        t_drop();
        t_slots();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule